// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a physically addressed data cache placed between a pipelined processor and a slow DRAM. The processor presents a 24-bit byte address, a read/write flag, write data and byte enables. A hit returns read data, or takes the write, in the same cycle with no stall. A miss raises a stall and keeps it high while the controller works. If the line to be replaced is dirty, the controller first bursts it back to memory. It then bursts the requested line in from memory. After that it drops the stall, and the held access hits on its retry.

Each line keeps a tag, a valid bit and a dirty bit. All ways of the selected set are compared in parallel. The victim in a set is the least recently used way. The memory side moves one 32-bit word per valid/ready handshake, so any memory latency is tolerated. Way count, set count and words per line are parameters. The set count and words per line must be powers of two, at least 2.

The processor must hold its request stable while the stall is high.

Top module: `wb_cache`

## Requirements
- R1: The address splits, from the bottom up, as follows: bits [1:0] are the byte within a word; the next log2(WORDS) bits are the word within the line; the next log2(SETS) bits are the set; all remaining upper bits are the tag. With 4-word lines and 8 sets, the word is addr[3:2], the set is addr[6:4] and the tag is addr[23:7].
- R2: An access hits when some way of the addressed set is valid and holds a matching tag. On a hit, cpu_stall stays low in that cycle, and a read returns the stored word on cpu_rdata in the same cycle.
- R3: At most one way of a set reports a hit at any time.
- R4: A write hit updates only the bytes whose enable is set, where cpu_be[i] covers data bits [8i+7:8i]. It marks the line dirty and causes no memory traffic.
- R5: Reset clears every valid bit, so the first access to any line after reset misses. While idle after reset, cpu_stall and mem_valid are low.
- R6: On a miss, cpu_stall is high from the first cycle of the access. The controller reads the line as WORDS beats at ascending word addresses starting at the line base. The filled line becomes valid and clean, and the retried access then hits.
- R7: When the victim is dirty, its WORDS words are written back at ascending addresses from the victim line's old base, all before any fill read. A clean victim causes no write beats.
- R8: The victim is the least recently used line of the set. Every hit counts as a use.
- R9: A memory beat completes in a cycle where mem_valid and mem_ready are both high. While mem_valid is high and mem_ready is low, mem_addr, mem_we and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Physical byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Read data, valid on a hit |
| cpu_stall | output | 1 | High while the access cannot complete |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | 24 | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_ready | input | 1 | Memory completes the beat |
| mem_rdata | input | 32 | Fill data, taken when mem_ready is high |

## Verification
The bench builds the cache with 2 ways, 8 sets and 4-word lines. With a set holding only two lines, a third tag forces an eviction after a few accesses. This makes least-recently-used victim choice, dirty write-back order and clean eviction easy to reach, both in directed sequences and in a random stream over four tags. The memory model's latency varies between one and four cycles, which exercises the hold rule on the burst interface. A reset in the middle of the run shows that cached lines are forgotten.

// File: rtl/wbc_pkg.sv
// Shared types and constants for the write-back cache.
// Assumes a 24-bit physical byte address and 32-bit words.
package wbc_pkg;
    localparam int PA_W   = 24;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
// Tag, valid and dirty state for every line, plus the parallel tag compare.
// Produces a hit vector for the addressed set (one comparator per way).
// Assumes fills and dirty marks never happen in the same cycle.
module wbc_tag_store #(
    parameter int WAYS  = 2,
    parameter int SETS  = 16,
    parameter int TAG_W = 16,
    parameter int IDX_W = 4,
    parameter int WAY_W = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            lk_idx,
    input  logic [TAG_W-1:0]            lk_tag,
    input  logic [WAYS-1:0]             mark_vec,
    input  logic                        fill_done,
    input  logic [WAY_W-1:0]            fill_way,
    output logic [WAYS-1:0]             hit_vec,
    output logic [WAYS-1:0]             dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0]  tag_vec
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];

    // Per-way compare and read-out of the addressed set.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
        assign tag_vec[w] = tag_q[lk_idx][w];
    end
    assign dirty_vec = dirty_q[lk_idx];

    // Valid/dirty upkeep: clear on reset, install on fill, mark on write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (fill_done) begin
            valid_q[lk_idx][fill_way] <= 1'b1;
            dirty_q[lk_idx][fill_way] <= 1'b0;
        end else begin
            dirty_q[lk_idx] <= dirty_q[lk_idx] | mark_vec;
        end
    end

    // Tag write on fill completion (tags need no reset).
    always_ff @(posedge clk) begin
        if (fill_done) tag_q[lk_idx][fill_way] <= lk_tag;
    end

    p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_reset_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hit_vec == '0));

    p_fill_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (valid_q[$past(lk_idx)][$past(fill_way)] &&
                       !dirty_q[$past(lk_idx)][$past(fill_way)]));

    p_dirty_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|mark_vec) |=> ((dirty_q[$past(lk_idx)] & $past(mark_vec)) == $past(mark_vec)));
endmodule

// File: rtl/wbc_lru.sv
// Least-recently-used tracking per set using age ranks.
// Each way holds a rank 0..WAYS-1 (0 = most recent); the rank WAYS-1 way is the victim.
// Assumes one touch per cycle at most.
module wbc_lru #(
    parameter int WAYS  = 2,
    parameter int SETS  = 16,
    parameter int IDX_W = 4,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] vic_way
);
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    int unsigned      n_oldest;

    // Rank update: the touched way becomes youngest, younger ones age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[idx][w] <= '0;
                else if (age_q[idx][w] < age_q[idx][touch_way])
                    age_q[idx][w] <= age_q[idx][w] + 1'b1;
            end
        end
    end

    // Victim pick: the way carrying the oldest rank in the addressed set.
    always_comb begin
        vic_way  = '0;
        n_oldest = 0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[idx][w] == WAY_W'(WAYS - 1)) begin
                vic_way  = WAY_W'(w);
                n_oldest = n_oldest + 1;
            end
        end
    end

    p_one_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        n_oldest == 1);
endmodule

// File: rtl/wbc_data_store.sv
// Line data storage with two combinational read ports (processor word, write-back beat)
// and one write port shared by byte-masked processor writes and fill beats.
// Assumes the controller never issues both writes in one cycle; holds no reset.
module wbc_data_store #(
    parameter int WAYS  = 2,
    parameter int SETS  = 16,
    parameter int WORDS = 4,
    parameter int IDX_W = 4,
    parameter int OFF_W = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    input  logic [WAY_W-1:0] cpu_way,
    input  logic [OFF_W-1:0] cpu_off,
    input  logic             cpu_wr,
    input  logic [3:0]       cpu_be,
    input  logic [31:0]      cpu_wdata,
    output logic [31:0]      cpu_rdata,
    input  logic [WAY_W-1:0] ln_way,
    input  logic [OFF_W-1:0] ln_off,
    input  logic             fill_en,
    input  logic [31:0]      fill_data,
    output logic [31:0]      wb_data
);
    logic [31:0] mem_q [SETS][WAYS][WORDS];

    assign cpu_rdata = mem_q[idx][cpu_way][cpu_off];
    assign wb_data   = mem_q[idx][ln_way][ln_off];

    // Word writes: byte lanes from the processor, whole words from the fill.
    always_ff @(posedge clk) begin
        if (cpu_wr) begin
            for (int b = 0; b < 4; b++)
                if (cpu_be[b]) mem_q[idx][cpu_way][cpu_off][8*b +: 8] <= cpu_wdata[8*b +: 8];
        end
        if (fill_en) mem_q[idx][ln_way][ln_off] <= fill_data;
    end
endmodule

// File: rtl/wb_cache.sv
// Set-associative write-back data cache controller.
// Hits complete in the cycle they are presented; a miss stalls, writes back a dirty
// LRU victim, bursts in the new line one word per valid/ready beat, then releases.
// Assumes the processor holds its request stable while cpu_stall is high and that
// SETS and WORDS are powers of two, at least 2.
module wb_cache
    import wbc_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int SETS  = 16,
    parameter int WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [PA_W-1:0]   cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [3:0]        cpu_be,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W = PA_W - 2 - OFF_W - IDX_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    wbc_state_e              state_q;
    logic [OFF_W-1:0]        beat_q;
    logic [WAY_W-1:0]        vic_q;

    logic [IDX_W-1:0]        a_idx;
    logic [OFF_W-1:0]        a_off;
    logic [TAG_W-1:0]        a_tag;
    logic [WAYS-1:0]         hit_vec, dirty_vec, mark_vec;
    logic [WAYS-1:0][TAG_W-1:0] tag_vec;
    logic                    any_hit, hit_acc, beat_last, fill_en, fill_done;
    logic [WAY_W-1:0]        hit_way, lru_vic;

    assign a_off = cpu_addr[2 +: OFF_W];
    assign a_idx = cpu_addr[2 + OFF_W +: IDX_W];
    assign a_tag = cpu_addr[PA_W-1 -: TAG_W];

    assign any_hit   = |hit_vec;
    assign hit_acc   = (state_q == ST_IDLE) && cpu_valid && any_hit;
    assign mark_vec  = hit_vec & {WAYS{hit_acc && cpu_we}};
    assign beat_last = (beat_q == LAST_BEAT);
    assign fill_en   = (state_q == ST_FILL) && mem_ready;
    assign fill_done = fill_en && beat_last;

    // Encode the one-hot hit vector into a way number.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    assign cpu_stall = cpu_valid && ((state_q != ST_IDLE) || !any_hit);
    assign mem_valid = (state_q != ST_IDLE);
    assign mem_we    = (state_q == ST_WBACK);
    assign mem_addr  = {(state_q == ST_WBACK) ? tag_vec[vic_q] : a_tag, a_idx, beat_q, 2'b00};

    wbc_tag_store #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .lk_idx(a_idx), .lk_tag(a_tag),
        .mark_vec(mark_vec), .fill_done(fill_done), .fill_way(vic_q),
        .hit_vec(hit_vec), .dirty_vec(dirty_vec), .tag_vec(tag_vec)
    );

    wbc_lru #(
        .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_lru (
        .clk(clk), .rst_n(rst_n), .idx(a_idx), .touch(hit_acc),
        .touch_way(hit_way), .vic_way(lru_vic)
    );

    wbc_data_store #(
        .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .IDX_W(IDX_W), .OFF_W(OFF_W), .WAY_W(WAY_W)
    ) u_data (
        .clk(clk), .idx(a_idx), .cpu_way(hit_way), .cpu_off(a_off),
        .cpu_wr(hit_acc && cpu_we), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .ln_way(vic_q), .ln_off(beat_q),
        .fill_en(fill_en), .fill_data(mem_rdata), .wb_data(mem_wdata)
    );

    // Miss sequencer: pick victim, optional write-back burst, then fill burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            vic_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cpu_valid && !any_hit) begin
                    vic_q   <= lru_vic;
                    beat_q  <= '0;
                    state_q <= dirty_vec[lru_vic] ? ST_WBACK : ST_FILL;
                end
                ST_WBACK: if (mem_ready) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_last) state_q <= ST_FILL;
                end
                ST_FILL: if (mem_ready) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_last) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_stall_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !any_hit) |-> cpu_stall);

    p_retry_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && cpu_valid) |=> any_hit);

    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/wb_cache_tb.sv
// Bench: behavioural cache model (per-set recency queues of line numbers, dirty set,
// flat reference memory) plus a DRAM model with adjustable latency.
module wb_cache_tb;
    localparam int WAYS   = 2;
    localparam int SETS   = 8;
    localparam int WORDS  = 4;
    localparam int LINE_B = WORDS * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_valid, mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    wb_cache #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    int lat   = 3;
    logic [31:0] dram [int];
    logic [31:0] refm [int];
    int          recq [SETS][$];
    bit          dirty_ln [int];

    function automatic logic [31:0] seed_word(int a);
        return (a * 32'h0100_0193) ^ 32'h5A5A_0000;
    endfunction
    function automatic logic [31:0] dram_rd(int a);
        return dram.exists(a) ? dram[a] : seed_word(a);
    endfunction
    function automatic logic [31:0] ref_rd(int a);
        return refm.exists(a) ? refm[a] : seed_word(a);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // One processor access, from request to completion, servicing memory beats.
    task automatic access(bit we, logic [23:0] a, logic [31:0] wd, logic [3:0] be);
        int ln = int'(a) / LINE_B;
        int st = ln % SETS;
        int pos = -1;
        bit exp_hit;
        int wbq[$];
        int rd_n = 0, wcnt = 0;
        logic [23:0] hold_a = '0;
        logic [31:0] old, nw;
        foreach (recq[st][i]) if (recq[st][i] == ln) pos = i;
        exp_hit = (pos >= 0);
        if (exp_hit) recq[st].delete(pos);
        else if (recq[st].size() == WAYS) begin
            int v = recq[st].pop_back();
            if (dirty_ln.exists(v)) begin
                for (int k = 0; k < WORDS; k++) wbq.push_back(v * LINE_B + 4 * k);
                dirty_ln.delete(v);
            end
        end
        recq[st].push_front(ln);

        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        #1;
        if (exp_hit) chk(!cpu_stall, "R2 hit completes without stall", 32'(cpu_stall), 0);
        else         chk(cpu_stall, "R6 miss raises stall", 32'(cpu_stall), 1);
        while (cpu_stall) begin
            if (mem_valid) begin
                if (wcnt == 0) hold_a = mem_addr;
                else chk(mem_addr == hold_a, "R9 address held while waiting", 32'(mem_addr), 32'(hold_a));
                wcnt++;
                if (wcnt >= lat) begin
                    mem_ready = 1'b1;
                    if (mem_we) begin
                        int ea = (wbq.size() > 0) ? wbq[0] : -1;
                        chk(int'(mem_addr) == ea, "R7 write-back beat address", 32'(mem_addr), 32'(ea));
                        chk(mem_wdata == ref_rd(int'(mem_addr)), "R7 write-back data",
                            mem_wdata, ref_rd(int'(mem_addr)));
                        if (wbq.size() > 0) void'(wbq.pop_front());
                        dram[int'(mem_addr)] = mem_wdata;
                    end else begin
                        chk(wbq.size() == 0, "R7 victim written before fill", 32'(wbq.size()), 0);
                        chk(int'(mem_addr) == ln * LINE_B + 4 * rd_n, "R6 fill beat address",
                            32'(mem_addr), 32'(ln * LINE_B + 4 * rd_n));
                        mem_rdata = dram_rd(int'(mem_addr));
                        rd_n++;
                    end
                    wcnt = 0;
                end
            end
            @(negedge clk);
            mem_ready = 1'b0;
            #1;
        end
        chk(rd_n == (exp_hit ? 0 : WORDS), "R6 fill beat count", 32'(rd_n), 32'(exp_hit ? 0 : WORDS));
        chk(wbq.size() == 0, "R7 all dirty victim words written", 32'(wbq.size()), 0);
        if (!we) begin
            chk(cpu_rdata == ref_rd(int'(a) & ~3), "R2 read data", cpu_rdata, ref_rd(int'(a) & ~3));
        end else begin
            old = ref_rd(int'(a) & ~3);
            nw  = old;
            for (int b = 0; b < 4; b++) if (be[b]) nw[8*b +: 8] = wd[8*b +: 8];
            refm[int'(a) & ~3] = nw;
            dirty_ln[ln] = 1'b1;
        end
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < SETS; s++) recq[s].delete();
        dirty_ln.delete();
        refm.delete();
        foreach (dram[k]) refm[k] = dram[k];
        #1;
        chk(!cpu_stall, "R5 no stall when idle after reset", 32'(cpu_stall), 0);
        chk(!mem_valid, "R5 no memory request after reset", 32'(mem_valid), 0);
        @(negedge clk);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog expired: stall never released actual=1 expected=0");
        summary();
        $finish;
    end

    localparam logic [23:0] LA = 24'h000100;
    localparam logic [23:0] LB = 24'h000180;
    localparam logic [23:0] LC = 24'h000200;

    initial begin
        @(negedge clk);
        do_reset();
        // R5: first touch of a line misses; R6 fill and retry.
        access(0, LA, 0, 0);
        access(0, LA, 0, 0);                        // R2 hit
        access(0, LA + 24'h8, 0, 0);                // R1 word field within same line
        access(0, LA + 24'h10, 0, 0);               // R1 next set, separate line
        access(1, LA + 24'h4, 32'hDEAD_BEEF, 4'b0101);   // R4 byte-masked write hit
        access(0, LA + 24'h4, 0, 0);                // R4 merged value read back
        access(0, LB, 0, 0);                        // second way of set 0
        access(0, LA, 0, 0);                        // R8 make LB least recent
        access(0, LC, 0, 0);                        // R8 evicts LB (clean, no write beats)
        access(0, LA, 0, 0);                        // R8 LA still resident
        access(0, LB, 0, 0);                        // evicts LC
        access(0, LC, 0, 0);                        // R7 evicts dirty LA: write-back first
        access(0, LA + 24'h4, 0, 0);                // R7 written-back data returns
        // R5: reset forgets everything
        access(1, LC + 24'hC, 32'h1234_5678, 4'b1111);
        do_reset();
        access(0, LC + 24'hC, 0, 0);
        // Random stream over four tags, varying memory latency (R9).
        for (int n = 0; n < 400; n++) begin
            logic [23:0] ra;
            ra  = 24'(((($urandom % 4) * 32'h1234) << 7) | (($urandom % SETS) << 4) | (($urandom % WORDS) << 2));
            lat = 1 + ($urandom % 4);
            access(($urandom % 2) == 1, ra, $urandom, 4'($urandom));
        end
        summary();
        $finish;
    end
endmodule